// File: doc/BRIEF.md
# Ranged Scan Fetch Engine

This block turns a queue of range requests into a stream of memory reads and an ordered stream of fetched words. Each request names a starting element index and an element count. The block computes each element's byte address from two configuration inputs: a base address and an element size. It issues one read per element and returns the fetched words on its output handshake in element order. After the final element of every range, it emits one end-of-range word.

Reads may complete in any order. A small table of tracking slots sets how many reads can be outstanding at once. Each slot also acts as a reorder position. A slot is held from the moment its read is issued until its word leaves the output, so the output never needs more room than the table provides. The end-of-range word also takes a slot, which places it behind the data of its own range.

The block never alters fetched data. It only computes addresses, keeps track of outstanding reads and restores their order.

Top module: `range_fetch`

## Requirements
- R1: The k-th read of a range (k counted from 0) is issued to byte address base + (offset + k) * esize, truncated to AW bits, and reads go out in increasing k.
- R2: A range with count n produces exactly n memory reads.
- R3: Once every data word of a range has left the output, exactly one further word follows with `out_last` = 1 and `out_data` all zero; data words carry `out_last` = 0.
- R4: A range with count zero produces no read and only the end-of-range word.
- R5: Fetched words leave the output unmodified and in element order, whatever order the responses come back in.
- R6: At no time are more than NT reads issued whose words have not yet left the output.
- R7: In the cycle after a range is accepted, `in_ready` is low. The next range is accepted only after the current range's end-of-range word has taken its slot.
- R8: After reset, `in_ready` is 1 and both `out_valid` and `mem_req_valid` are 0.
- R9: A read is never issued with a tag that another outstanding read still holds, and each response is placed in the slot its tag names.
- R10: While `out_valid` is high and `out_ready` low, the output word and its end flag stay unchanged. While `mem_req_valid` is high and `mem_req_ready` low, the address and tag stay unchanged.
- R11: Base and element size are sampled when a range is accepted. Later changes to them do not affect the range in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Array base byte address |
| cfg_esize | input | ESW | Element size in bytes |
| in_valid | input | 1 | Range request present |
| in_ready | output | 1 | Range request accepted this cycle when high with in_valid |
| in_offset | input | AW | First element index of the range |
| in_count | input | CW | Number of elements in the range |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | AW | Read byte address |
| mem_req_tag | output | $clog2(NT) | Slot tag of the read |
| mem_rsp_valid | input | 1 | Read response valid, always accepted |
| mem_rsp_tag | input | $clog2(NT) | Tag of the returning read |
| mem_rsp_data | input | DW | Returned word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DW | Fetched word, zero for the end-of-range word |
| out_last | output | 1 | End-of-range flag |

## Verification
Once a range is accepted, its first read can appear combinationally in the next cycle. Later reads follow one per accepted handshake, and `in_ready` must be low in that next cycle. A response registered at a clock edge makes its word visible at the output after that same edge, provided every earlier slot is already filled. The bench therefore drives all inputs at the falling edge and samples one time unit later. In each sampled cycle it checks read handshakes against a queue of expected addresses, output handshakes against a queue of expected words, the open-read count and output stability. It never needs to predict an exact latency, because the memory model reorders responses at random and both handshakes stall at random.

// File: rtl/range_fetch.sv
module range_fetch #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int ESW = 8,
  parameter int NT  = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cfg_base,
  input  logic [ESW-1:0] cfg_esize,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [AW-1:0]  in_offset,
  input  logic [CW-1:0]  in_count,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  output logic [TW-1:0]  mem_req_tag,
  input  logic           mem_rsp_valid,
  input  logic [TW-1:0]  mem_rsp_tag,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_last
);

  logic           active;
  logic [AW-1:0]  addr;
  logic [CW-1:0]  left;
  logic [ESW-1:0] step;
  logic [TW-1:0]  wp, rp;
  logic [TW:0]    used;
  logic [NT-1:0]  filled, mark;
  logic [DW-1:0]  rob [NT];

  wire full       = (used == (TW+1)'(NT));
  wire mark_alloc = active && (left == '0) && !full;
  wire req_go     = mem_req_valid && mem_req_ready;
  wire alloc      = req_go || mark_alloc;
  wire drain      = out_valid && out_ready;
  wire accept     = in_valid && in_ready;

  assign in_ready      = !active;
  assign mem_req_valid = active && (left != '0) && !full;
  assign mem_req_addr  = addr;
  assign mem_req_tag   = wp;
  assign out_valid     = (used != '0) && filled[rp];
  assign out_data      = rob[rp];
  assign out_last      = mark[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr   <= '0;
      left   <= '0;
      step   <= '0;
      wp     <= '0;
      rp     <= '0;
      used   <= '0;
      filled <= '0;
      mark   <= '0;
    end else begin
      if (accept) begin
        active <= 1'b1;
        addr   <= cfg_base + in_offset * AW'(cfg_esize);
        step   <= cfg_esize;
        left   <= in_count;
      end
      if (req_go) begin
        addr     <= addr + AW'(step);
        left     <= left - 1'b1;
        mark[wp] <= 1'b0;
      end
      if (mark_alloc) begin
        active     <= 1'b0;
        mark[wp]   <= 1'b1;
        filled[wp] <= 1'b1;
      end
      if (alloc)
        wp <= (wp == TW'(NT-1)) ? '0 : wp + 1'b1;
      if (mem_rsp_valid)
        filled[mem_rsp_tag] <= 1'b1;
      if (drain) begin
        filled[rp] <= 1'b0;
        rp         <= (rp == TW'(NT-1)) ? '0 : rp + 1'b1;
      end
      used <= used + (TW+1)'(alloc) - (TW+1)'(drain);
    end
  end

  always_ff @(posedge clk) begin
    if (mark_alloc)
      rob[wp] <= '0;
    if (mem_rsp_valid)
      rob[mem_rsp_tag] <= mem_rsp_data;
  end

endmodule

// File: rtl/range_fetch_chk.sv
module range_fetch_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NT = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic [TW-1:0] mem_req_tag,
  input logic          mem_rsp_valid,
  input logic [TW-1:0] mem_rsp_tag,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last
);

  logic [NT-1:0] inflight;
  logic [TW+1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      pend     <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) inflight[mem_req_tag] <= 1'b1;
      if (mem_rsp_valid) inflight[mem_rsp_tag] <= 1'b0;
      pend <= pend + (TW+2)'(mem_req_valid && mem_req_ready)
                   - (TW+2)'(out_valid && out_ready && !out_last);
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_marker_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_data == '0);

  assert_open_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= (TW+2)'(NT));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_tag_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |-> !inflight[mem_req_tag]);

  assert_rsp_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> inflight[mem_rsp_tag]);

endmodule

bind range_fetch range_fetch_chk #(.AW(AW), .DW(DW), .NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/sim_range_fetch.sv
module sim_range_fetch;
  localparam int NT = 4;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [7:0]  cfg_esize = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_offset = '0;
  logic [15:0] in_count = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_tag;
  logic        mem_rsp_valid = 1'b0;
  logic [1:0]  mem_rsp_tag = '0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;

  always #10 clk = ~clk;

  range_fetch #(.AW(32), .DW(32), .CW(16), .ESW(8), .NT(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_esize(cfg_esize),
    .in_valid(in_valid), .in_ready(in_ready), .in_offset(in_offset), .in_count(in_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit run = 1'b0;
  int pct_out = 100, pct_mem = 100, pct_gap = 0;

  int unsigned rq_off[$], rq_cnt[$], rq_base[$], rq_es[$];
  logic [31:0] exp_addr[$], exp_dat[$];
  bit          exp_last[$];
  string       exp_lbl[$];
  int          p_tag[$], p_dly[$];
  logic [31:0] p_addr[$];
  int  reads_open = 0;
  bit  prev_hold = 1'b0, just_acc = 1'b0, prev_last = 1'b0;
  logic [31:0] prev_data = '0;

  function automatic logic [31:0] memval(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C3_5A5A;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_range(int unsigned b, int unsigned e, int unsigned o, int unsigned c);
    rq_base.push_back(b); rq_es.push_back(e); rq_off.push_back(o); rq_cnt.push_back(c);
  endtask

  always @(posedge clk) cycles++;

  always @(negedge clk) if (run) begin
    mem_rsp_valid = 1'b0;
    foreach (p_dly[i]) p_dly[i]--;
    for (int i = p_dly.size() - 1; i >= 0; i--) begin
      if (p_dly[i] <= 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = 2'(p_tag[i]);
        mem_rsp_data  = memval(p_addr[i]);
        p_tag.delete(i); p_dly.delete(i); p_addr.delete(i);
        break;
      end
    end
    if (rq_off.size() > 0 && (in_valid || $urandom_range(99) >= pct_gap)) begin
      in_valid  = 1'b1;
      cfg_base  = rq_base[0];
      cfg_esize = 8'(rq_es[0]);
      in_offset = rq_off[0];
      in_count  = 16'(rq_cnt[0]);
    end else begin
      in_valid  = 1'b0;
      cfg_base  = $urandom;
      cfg_esize = 8'($urandom);
      in_offset = $urandom;
      in_count  = 16'($urandom);
    end
    out_ready     = ($urandom_range(99) < pct_out);
    mem_req_ready = ($urandom_range(99) < pct_mem);
    #1;
    if (prev_hold)
      check(out_valid && out_data == prev_data && out_last == prev_last, "R10", "held output",
            {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
    prev_last = out_last;
    if (just_acc) check(!in_ready, "R7", "in_ready after accept", in_ready, 0);
    just_acc = 1'b0;
    if (in_valid && in_ready) begin
      for (int k = 0; k < int'(rq_cnt[0]); k++) begin
        logic [31:0] a;
        a = rq_base[0] + (rq_off[0] + k) * rq_es[0];
        exp_addr.push_back(a);
        exp_dat.push_back(memval(a));
        exp_last.push_back(1'b0);
        exp_lbl.push_back("R5");
      end
      exp_dat.push_back('0);
      exp_last.push_back(1'b1);
      exp_lbl.push_back(rq_cnt[0] == 0 ? "R4" : "R3");
      rq_base.pop_front(); rq_es.pop_front(); rq_off.pop_front(); rq_cnt.pop_front();
      just_acc = 1'b1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (exp_addr.size() == 0) begin
        check(1'b0, "R2", "unexpected read", mem_req_addr, 0);
      end else begin
        check(mem_req_addr == exp_addr[0], "R1,R11", "read address", mem_req_addr, exp_addr[0]);
        void'(exp_addr.pop_front());
      end
      begin
        bit clash;
        clash = 1'b0;
        foreach (p_tag[i]) if (p_tag[i] == int'(mem_req_tag)) clash = 1'b1;
        check(!clash, "R9", "tag reuse", mem_req_tag, 0);
      end
      p_tag.push_back(int'(mem_req_tag));
      p_addr.push_back(mem_req_addr);
      p_dly.push_back($urandom_range(6, 1));
      reads_open++;
    end
    if (out_valid && out_ready) begin
      if (exp_dat.size() == 0) begin
        check(1'b0, "R3", "unexpected output", {out_last, out_data}, 0);
      end else begin
        check(out_data == exp_dat[0] && out_last == exp_last[0], exp_lbl[0], "output word",
              {out_last, out_data}, {exp_last[0], exp_dat[0]});
        void'(exp_dat.pop_front()); void'(exp_last.pop_front()); void'(exp_lbl.pop_front());
      end
      if (!out_last) reads_open--;
    end
    check(reads_open <= NT, "R6", "open reads", reads_open, NT);
  end

  task automatic wait_idle();
    while (!(rq_off.size() == 0 && exp_dat.size() == 0 && p_tag.size() == 0 && !in_valid)
           && cycles < LIMIT)
      @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(mem_req_valid == 1'b0, "R8", "mem_req_valid after reset", mem_req_valid, 0);
    @(negedge clk);

    add_range(32'h1000, 4, 0, 1);
    add_range(32'h1000, 4, 5, 3);
    add_range(32'h2000, 8, 7, 0);
    add_range(32'h0, 1, 3, 9);
    add_range(32'h4000, 4, 2, 0);
    add_range(32'h4000, 4, 3, 0);
    add_range(32'h8000, 2, 10, 6);
    add_range(32'hFFFF_FFF0, 4, 2, 5);
    run = 1'b1;
    wait_idle();

    pct_out = 60; pct_mem = 70; pct_gap = 40;
    for (int i = 0; i < 30; i++)
      add_range({$urandom_range(255), 8'h00}, 1 << $urandom_range(3), $urandom_range(1000),
                $urandom_range(12));
    wait_idle();

    pct_out = 20; pct_mem = 100; pct_gap = 0;
    for (int i = 0; i < 10; i++)
      add_range(32'h3000, 4, 16 * i, $urandom_range(10, 2));
    wait_idle();

    if (cycles >= LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
    end
    check(exp_addr.size() == 0, "R2", "reads missing", exp_addr.size(), 0);
    run = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule